// File: doc/BRIEF.md
# Dual-Mode Zero-Substitution Line Encoder

This block converts a transmit bit stream from terminal equipment into a bipolar line code. The code is carried on a positive-rail and negative-rail output pair. Long strings of zeros would starve the far-end clock recovery, so the encoder replaces them with code words that contain a deliberate bipolar violation. For the DS3 and STS-1 line rates it uses the three-zero code (B3ZS). For E3 it uses the four-zero code (HDB3). The line-mode input selects one code or the other, and a single datapath serves both.

The data can arrive in one of two forms. In single-rail form, one binary data line carries the stream and the negative-rail input is unused. In dual-rail form, two inputs are provided. Every input is captured on the falling edge of the clock. The stream then passes through a four-slot lookahead window, where a zero run can be rewritten before any of it leaves the block. A final stage assigns the line polarity. Single-rail operation always runs the encoder. Dual-rail operation with the encoder disabled copies the two rails to the outputs, with the same delay as the encoded path.

Top module: `zsub_line_encoder`

## Requirements
- R1: When `cfg_line_mode` is 2'b00 (DS3), 2'b01 (STS-1) or 2'b11, the encoder substitutes every run of three zeros (B3ZS).
- R2: When `cfg_line_mode` is 2'b10 (E3), the encoder substitutes every run of four zeros (HDB3).
- R3: The substitution is the all-zero word ending in V (00V or 000V) when an odd number of marks entered since the last substitution. It is the word starting with B and ending in V (B0V or B00V) when that number is even. Only the first zero of the run becomes the B pulse.
- R4: Ordinary marks and B pulses alternate in polarity. A V pulse repeats the polarity of the pulse before it. While encoding, the two rails are never high together, and a pulse is line_pos=1/line_neg=0 for positive and 0/1 for negative.
- R5: While encoding, once the first pulse has left the block, the line carries at most 2 consecutive zero periods in B3ZS and at most 3 in HDB3.
- R6: Input data is captured on the falling clock edge. A change on `tx_pos_in` after that edge and before the next rising edge has no effect.
- R7: With `cfg_single_rail`=1, `tx_neg_in` has no effect on the outputs.
- R8: With `cfg_single_rail`=1, the encoder runs whatever the value of `cfg_enc_en`.
- R9: With `cfg_single_rail`=0 and `cfg_enc_en`=0, `tx_pos_in` and `tx_neg_in` appear unchanged on `line_pos` and `line_neg`.
- R10: Every mode has the same latency. A bit driven after rising edge t shows its code on the outputs after rising edge t+5.
- R11: While `rst_n` is low, both outputs go low on the next rising edge. Reset also clears the mark parity to even and sets the polarity so that the first pulse after reset is positive.
- R12: With `cfg_single_rail`=0 and the encoder enabled, the data bit is the OR of `tx_pos_in` and `tx_neg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; inputs captured on falling edge, outputs change on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_single_rail | input | 1 | 1 = single binary input on tx_pos_in |
| cfg_line_mode | input | 2 | 2'b10 = E3 (HDB3), other values = DS3/STS-1 (B3ZS) |
| cfg_enc_en | input | 1 | Encoder enable for dual-rail input |
| tx_pos_in | input | 1 | Binary data (single-rail) or positive rail (dual-rail) |
| tx_neg_in | input | 1 | Negative rail (dual-rail only) |
| line_pos | output | 1 | Positive-rail line pulse |
| line_neg | output | 1 | Negative-rail line pulse |

## Verification
Each result is due five rising edges after the edge that precedes the bit's drive. That delay is one falling-edge capture, four window slots and one polarity register. The bench drives a bit just after a rising edge and reads the output just after the following edge, where it expects the code of the bit driven four iterations earlier. It expects zeros for the first four reads after reset. A bench function builds the expected line sequence from the whole input stream, including the trailing zeros that can complete a substitution, so a B pulse placed on an earlier bit is still checked at that bit's own due cycle.

// File: rtl/zsub_pkg.sv
// Shared types for the zero-substitution line encoder.
// Assumes: one slot per bit period in the lookahead window.
package zsub_pkg;

    // Role of one bit period inside the lookahead window.
    typedef enum logic [2:0] {
        K_IDLE = 3'd0,   // reset filler, never part of a zero run
        K_ZERO = 3'd1,   // plain zero, may still be rewritten
        K_ONE  = 3'd2,   // ordinary mark
        K_BPUL = 3'd3,   // balancing pulse inserted by substitution
        K_VPUL = 3'd4    // violation pulse inserted by substitution
    } kind_e;

    // One window slot: coded role plus the raw rails for pass-through.
    typedef struct packed {
        kind_e kind;
        logic  rp;
        logic  rn;
    } slot_t;

endpackage

// File: rtl/zsub_capture.sv
// Input capture stage of the line encoder.
// Registers the terminal-side inputs on the falling clock edge and
// forms the data bit: tx_pos_in alone in single-rail form, OR of rails
// in dual-rail form. Assumes inputs settle before the falling edge.
module zsub_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic single_rail,
    input  logic pos_in,
    input  logic neg_in,
    output logic data_o,
    output logic rp_o,
    output logic rn_o
);

    // Falling-edge capture of data bit and raw rails.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            data_o <= 1'b0;
            rp_o   <= 1'b0;
            rn_o   <= 1'b0;
        end else begin
            data_o <= single_rail ? pos_in : (pos_in | neg_in);
            rp_o   <= pos_in;
            rn_o   <= single_rail ? 1'b0 : neg_in;
        end
    end

endmodule

// File: rtl/zsub_window.sv
// Lookahead window and substitution logic.
// A new slot enters each rising edge. When the arriving zero completes a
// run of RUN zeros (3 for B3ZS, 4 for HDB3), the new slot becomes V and,
// if the mark parity since the last substitution is even, the first zero
// of the run becomes B. Assumes DEPTH >= the HDB3 run length.
module zsub_window #(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc,
    input  logic            hdb3,
    input  logic            data_i,
    input  logic            rp_i,
    input  logic            rn_i,
    output zsub_pkg::slot_t head_o
);
    import zsub_pkg::*;

    localparam int B3_RUN = 3;
    localparam int HD_RUN = 4;

    slot_t win [DEPTH];
    slot_t nxt [DEPTH];
    logic  odd_q;
    logic  odd_d;
    logic  subst;
    int    run_len;

    // Next window contents, run detection and parity update.
    always_comb begin
        run_len = hdb3 ? HD_RUN : B3_RUN;
        subst   = enc && !data_i;
        for (int k = 0; k < DEPTH - 1; k++) begin
            if (k < run_len - 1 && win[k].kind != K_ZERO) subst = 1'b0;
        end
        nxt[0].kind = data_i ? K_ONE : K_ZERO;
        nxt[0].rp   = rp_i;
        nxt[0].rn   = rn_i;
        for (int k = 1; k < DEPTH; k++) nxt[k] = win[k-1];
        odd_d = odd_q;
        if (enc && data_i) odd_d = !odd_q;
        if (subst) begin
            nxt[0].kind = K_VPUL;
            if (!odd_q) begin
                for (int k = 1; k < DEPTH; k++) begin
                    if (k == run_len - 1) nxt[k].kind = K_BPUL;
                end
            end
            odd_d = 1'b0;
        end
    end

    // Window shift and parity register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) win[k] <= '{kind: K_IDLE, rp: 1'b0, rn: 1'b0};
            odd_q <= 1'b0;
        end else begin
            win   <= nxt;
            odd_q <= odd_d;
        end
    end

    assign head_o = win[DEPTH-1];

endmodule

// File: rtl/zsub_polarity.sv
// Output stage: turns slot roles into line pulses.
// Marks and B pulses take the opposite polarity of the last pulse; V
// repeats it. With the encoder off, raw rails are copied. Assumes the
// polarity state starts negative so the first pulse is positive.
module zsub_polarity (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc,
    input  zsub_pkg::slot_t head_i,
    output logic            out_pos,
    output logic            out_neg
);
    import zsub_pkg::*;

    logic last_pos_q;

    // Registered pulse generation and polarity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pos    <= 1'b0;
            out_neg    <= 1'b0;
            last_pos_q <= 1'b0;
        end else if (!enc) begin
            out_pos <= head_i.rp;
            out_neg <= head_i.rn;
        end else begin
            case (head_i.kind)
                K_ONE, K_BPUL: begin
                    out_pos    <= !last_pos_q;
                    out_neg    <= last_pos_q;
                    last_pos_q <= !last_pos_q;
                end
                K_VPUL: begin
                    out_pos <= last_pos_q;
                    out_neg <= !last_pos_q;
                end
                default: begin
                    out_pos <= 1'b0;
                    out_neg <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/zsub_line_encoder.sv
// Dual-mode zero-substitution line encoder, top level.
// Chains falling-edge capture, a DEPTH-slot lookahead window and the
// polarity stage. Single-rail form forces the encoder on. Assumes the
// configuration inputs change only while rst_n is low.
module zsub_line_encoder #(
    parameter int WIN_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_single_rail,
    input  logic [1:0] cfg_line_mode,
    input  logic       cfg_enc_en,
    input  logic       tx_pos_in,
    input  logic       tx_neg_in,
    output logic       line_pos,
    output logic       line_neg
);
    import zsub_pkg::*;

    localparam logic [1:0] MODE_E3 = 2'b10;

    logic  enc;
    logic  hdb3;
    logic  cap_data;
    logic  cap_rp;
    logic  cap_rn;
    slot_t head;

    // Effective encoder enable and code selection.
    always_comb begin
        enc  = cfg_single_rail | cfg_enc_en;
        hdb3 = (cfg_line_mode == MODE_E3);
    end

    zsub_capture i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_rail (cfg_single_rail),
        .pos_in      (tx_pos_in),
        .neg_in      (tx_neg_in),
        .data_o      (cap_data),
        .rp_o        (cap_rp),
        .rn_o        (cap_rn)
    );

    zsub_window #(.DEPTH(WIN_DEPTH)) i_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .enc    (enc),
        .hdb3   (hdb3),
        .data_i (cap_data),
        .rp_i   (cap_rp),
        .rn_i   (cap_rn),
        .head_o (head)
    );

    zsub_polarity i_polarity (
        .clk     (clk),
        .rst_n   (rst_n),
        .enc     (enc),
        .head_i  (head),
        .out_pos (line_pos),
        .out_neg (line_neg)
    );

endmodule

// File: rtl/zsub_line_encoder_chk.sv
// Property checker for zsub_line_encoder, attached by bind.
// Watches only the ports; tracks zero runs, same-polarity streaks and
// cycles since reset with small saturating counters.
module zsub_line_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_single_rail,
    input logic [1:0] cfg_line_mode,
    input logic       cfg_enc_en,
    input logic       tx_pos_in,
    input logic       tx_neg_in,
    input logic       line_pos,
    input logic       line_neg
);

    logic       enc;
    logic [2:0] zero_lim;
    logic [2:0] zrun;
    logic       armed;
    logic       last_pol;
    logic [1:0] streak;
    logic [2:0] warm;
    logic       pulse;

    // Effective mode seen from the ports.
    always_comb begin
        enc      = cfg_single_rail | cfg_enc_en;
        zero_lim = (cfg_line_mode == 2'b10) ? 3'd3 : 3'd2;
        pulse    = line_pos | line_neg;
    end

    // Zero-run, polarity-streak and warm-up counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun     <= 3'd0;
            armed    <= 1'b0;
            last_pol <= 1'b0;
            streak   <= 2'd0;
            warm     <= 3'd0;
        end else begin
            if (warm != 3'd7) warm <= warm + 3'd1;
            if (pulse) begin
                zrun     <= 3'd0;
                armed    <= 1'b1;
                last_pol <= line_pos;
                if (armed && line_pos == last_pol) begin
                    if (streak != 2'd3) streak <= streak + 2'd1;
                end else begin
                    streak <= 2'd1;
                end
            end else if (armed && zrun != 3'd7) begin
                zrun <= zrun + 3'd1;
            end
        end
    end

    assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enc |-> !(line_pos && line_neg));

    assert_mark_streak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enc |-> streak <= 2'd2);

    assert_zero_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc && armed) |-> zrun <= zero_lim);

    assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc && warm >= 3'd6) |->
            (line_pos == $past(tx_pos_in, 5) && line_neg == $past(tx_neg_in, 5)));

endmodule

bind zsub_line_encoder zsub_line_encoder_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_single_rail (cfg_single_rail),
    .cfg_line_mode   (cfg_line_mode),
    .cfg_enc_en      (cfg_enc_en),
    .tx_pos_in       (tx_pos_in),
    .tx_neg_in       (tx_neg_in),
    .line_pos        (line_pos),
    .line_neg        (line_neg)
);

// File: tb/test_zsub_line_encoder.sv
// Self-checking bench: per segment, a fixed-seed stream is encoded by a
// bench model and compared bit by bit at the five-edge due cycle.
module test_zsub_line_encoder;

    localparam int SEG_LEN = 160;
    localparam int TOT     = SEG_LEN + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_single_rail = 1'b0;
    logic [1:0] cfg_line_mode = 2'b00;
    logic       cfg_enc_en = 1'b0;
    logic       tx_pos_in = 1'b0;
    logic       tx_neg_in = 1'b0;
    logic       line_pos;
    logic       line_neg;

    int checks = 0;
    int failures = 0;

    bit sp [TOT];
    bit sn [TOT];
    bit ep [TOT];
    bit en [TOT];

    always #2 clk = ~clk;   // 250 MHz

    zsub_line_encoder i_zsub_line_encoder (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_single_rail (cfg_single_rail),
        .cfg_line_mode   (cfg_line_mode),
        .cfg_enc_en      (cfg_enc_en),
        .tx_pos_in       (tx_pos_in),
        .tx_neg_in       (tx_neg_in),
        .line_pos        (line_pos),
        .line_neg        (line_neg)
    );

    task automatic check(input string tag, input int idx, input bit xp, input bit xn);
        checks++;
        if (line_pos !== xp || line_neg !== xn) begin
            failures++;
            $display("FAIL %s bit %0d: got pos=%b neg=%b expected pos=%b neg=%b",
                     tag, idx, line_pos, line_neg, xp, xn);
        end
    endtask

    // Bench model: sequential zero counting with back-patching of B.
    function automatic void build_expected(input bit single, input bit enc, input bit hdb3);
        int  kind [TOT];
        int  zc = 0;
        int  run = hdb3 ? 4 : 3;
        bit  par = 1'b0;
        bit  lastpos = 1'b0;
        for (int i = 0; i < TOT; i++) begin
            bit d = single ? sp[i] : (sp[i] | sn[i]);
            if (d) begin
                kind[i] = 1; par = !par; zc = 0;
            end else begin
                kind[i] = 0; zc++;
                if (zc == run) begin
                    kind[i] = 3;
                    if (!par) kind[i-run+1] = 2;
                    par = 1'b0; zc = 0;
                end
            end
        end
        for (int i = 0; i < TOT; i++) begin
            if (!enc) begin
                ep[i] = sp[i]; en[i] = sn[i];
            end else if (kind[i] == 1 || kind[i] == 2) begin
                ep[i] = !lastpos; en[i] = lastpos; lastpos = !lastpos;
            end else if (kind[i] == 3) begin
                ep[i] = lastpos; en[i] = !lastpos;
            end else begin
                ep[i] = 1'b0; en[i] = 1'b0;
            end
        end
    endfunction

    // pat: 0 biased random, 1 all zeros, 2 one mark per five bits, 3 all ones
    task automatic run_seg(input bit single, input logic [1:0] mode, input bit ena,
                           input int pat, input string tag);
        bit enc = single | ena;
        rst_n = 1'b0;
        cfg_single_rail = single;
        cfg_line_mode = mode;
        cfg_enc_en = ena;
        tx_pos_in = 1'b0;
        tx_neg_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check({tag, " R11 reset"}, -1, 1'b0, 1'b0);
        for (int i = 0; i < TOT; i++) begin
            if (i >= SEG_LEN) begin
                sp[i] = 1'b0; sn[i] = 1'b0;
            end else begin
                case (pat)
                    0:       sp[i] = ($urandom % 4) == 0;
                    1:       sp[i] = 1'b0;
                    2:       sp[i] = (i % 5) == 0;
                    default: sp[i] = 1'b1;
                endcase
                if (single)        sn[i] = $urandom % 2;   // R7: must be ignored
                else if (pat == 1) sn[i] = 1'b0;
                else if (enc)      sn[i] = ($urandom % 7) == 0;
                else               sn[i] = $urandom % 2;
            end
        end
        build_expected(single, enc, mode == 2'b10);
        rst_n = 1'b1;
        for (int j = 0; j < SEG_LEN + 4; j++) begin
            tx_pos_in = sp[j];
            tx_neg_in = sn[j];
            if (single) begin
                #2 tx_pos_in = ~sp[j];   // R6: change after the falling edge
            end
            @(posedge clk);
            #1;
            // R10: bit driven in iteration j-4 is due now
            if (j < 4) check(tag, j - 4, 1'b0, 1'b0);
            else       check(tag, j - 4, ep[j-4], en[j-4]);
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run_seg(1'b1, 2'b00, 1'b1, 0, "R1 R3 R4 R6 R7 R10 DS3");
        run_seg(1'b1, 2'b01, 1'b1, 2, "R1 R3 R4 STS-1");
        run_seg(1'b1, 2'b10, 1'b1, 0, "R2 R3 R4 R6 R7 E3");
        run_seg(1'b1, 2'b10, 1'b1, 1, "R2 R5 E3 zeros");
        run_seg(1'b1, 2'b00, 1'b0, 1, "R8 R5 DS3 zeros");
        run_seg(1'b1, 2'b11, 1'b0, 0, "R8 R1 mode3");
        run_seg(1'b0, 2'b10, 1'b1, 0, "R12 E3 dual");
        run_seg(1'b0, 2'b00, 1'b1, 2, "R12 DS3 dual");
        run_seg(1'b0, 2'b00, 1'b0, 0, "R9 R10 pass");
        run_seg(1'b0, 2'b10, 1'b0, 0, "R9 pass E3");
        run_seg(1'b1, 2'b00, 1'b1, 3, "R4 R11 ones");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule